// File: doc/BRIEF.md
# Floating-Point Compare Condition Unit

This block compares two IEEE-754 operands, either both single precision or both double precision, and reduces the comparison to one condition bit. Each operand is sorted into zero, finite, infinity, quiet NaN or signaling NaN. The unit then derives three exclusive relations: less, equal and unordered. A 4-bit predicate code picks any OR of the three relations. The top bit of that code makes quiet NaNs raise the invalid-operation status.

A request is one `in_valid` strobe carrying both operand buses, the format select, the predicate, an absolute-value option and the index of the target condition-code bit. One clock later the unit pulses `out_done`. With it come the result bit, a one-hot write mask that points at the chosen condition code, and the invalid-operation status. The condition-code register file and any trapping sit outside this block.

Top module: `fp_cond_cmp`

## Requirements
- R1: The result is the OR of three terms: predicate bit 2 AND less, predicate bit 1 AND equal, and predicate bit 0 AND unordered. A predicate of 0 always gives 0.
- R2: If either operand is a NaN, less and equal are both 0 and unordered is 1. At most one of the three relations is ever true.
- R3: Invalid-operation status is 1 exactly when a NaN is present and either predicate bit 3 is 1 or one of the operands is a signaling NaN. Ordered operands never raise it.
- R4: Ordered operands are compared by sign and magnitude. Positive zero equals negative zero. When both operands are negative, the larger magnitude is the smaller value. Infinities and denormals order like any other finite encoding. Less is 1 only when the operands are not equal and the first is smaller.
- R5: When `abs_en` is 1, the sign bits of both operands are cleared before ordering. NaN detection is not affected.
- R6: `fmt_dbl`=0 selects single precision, taken from bits 31:0 of each bus. In that mode bits 63:32 have no effect. `fmt_dbl`=1 selects double precision, using all 64 bits.
- R7: On each `out_done` pulse, `out_cc_wmask` has exactly one bit set, at position `cc_idx` of the request. When `out_done` is 0 the mask is all zeros.
- R8: `out_done`, `out_result`, `out_invalid` and `out_cc_wmask` are registered and appear in the cycle after the `in_valid` cycle. After reset all outputs are 0, and `out_done` is 0 in any cycle that does not follow a strobe.
- R9: A NaN has an all-ones exponent and a nonzero fraction. It is signaling when the most significant fraction bit is 0 and quiet when that bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 64 | First operand bus |
| op_b | input | 64 | Second operand bus |
| fmt_dbl | input | 1 | 1 = double precision, 0 = single precision (low 32 bits) |
| pred | input | 4 | Predicate: bit 2 less, bit 1 equal, bit 0 unordered, bit 3 signal on quiet NaN |
| abs_en | input | 1 | Compare magnitudes only |
| cc_idx | input | CCW (3) | Target condition-code index |
| out_done | output | 1 | One-cycle completion pulse |
| out_result | output | 1 | Condition bit to be written |
| out_cc_wmask | output | NCC (8) | One-hot write mask for the condition code |
| out_invalid | output | 1 | Invalid-operation status |

## Verification
The bench builds the unit with its default eight condition codes. That puts both the lowest and the highest code index within reach, so the mask is checked at both ends and at an interior position. The format parameters stay at the standard single and double layouts. This lets the directed encodings (signed zeros, smallest denormal, infinities, quiet and signaling NaNs with one fraction bit moved) land on the exact field boundaries the classifier decodes. One case places conflicting upper-half bits under a single-precision compare, which shows that the upper half is ignored.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

  localparam int OPW      = 64;
  localparam int MAGW     = OPW - 1;
  localparam int SP_EXPW  = 8;
  localparam int SP_FRACW = 23;
  localparam int SP_W     = 1 + SP_EXPW + SP_FRACW;
  localparam int DP_EXPW  = 11;
  localparam int DP_FRACW = 52;

  typedef struct packed {
    logic            sign;
    logic            nan;
    logic            snan;
    logic            zero;
    logic [MAGW-1:0] mag;
  } fpcc_opnd_t;

  typedef struct packed {
    logic lt;
    logic eq;
    logic un;
  } fpcc_rel_t;

  // Split one operand bus into classification fields.
  function automatic fpcc_opnd_t f_unpack(input logic [OPW-1:0] bits,
                                          input logic dbl,
                                          input logic absv);
    fpcc_opnd_t o;
    logic exp_ones;
    logic frac_nz;
    logic frac_msb;
    if (dbl) begin
      exp_ones = &bits[DP_FRACW +: DP_EXPW];
      frac_nz  = |bits[DP_FRACW-1:0];
      frac_msb = bits[DP_FRACW-1];
      o.sign   = bits[OPW-1];
      o.mag    = bits[MAGW-1:0];
    end else begin
      exp_ones = &bits[SP_FRACW +: SP_EXPW];
      frac_nz  = |bits[SP_FRACW-1:0];
      frac_msb = bits[SP_FRACW-1];
      o.sign   = bits[SP_W-1];
      o.mag    = {{(MAGW-SP_W+1){1'b0}}, bits[SP_W-2:0]};
    end
    if (absv) o.sign = 1'b0;
    o.nan  = exp_ones & frac_nz;
    o.snan = exp_ones & frac_nz & ~frac_msb;
    o.zero = (o.mag == '0);
    return o;
  endfunction

  // Sign-magnitude ordering of two non-NaN operands.
  function automatic fpcc_rel_t f_order(input fpcc_opnd_t a, input fpcc_opnd_t b);
    fpcc_rel_t r;
    logic m_lt;
    logic m_gt;
    m_lt = (a.mag < b.mag);
    m_gt = (a.mag > b.mag);
    r.un = 1'b0;
    r.eq = (a.zero & b.zero) | ((a.sign == b.sign) & (a.mag == b.mag));
    r.lt = ~r.eq & (( a.sign & ~b.sign) |
                    (~a.sign & ~b.sign & m_lt) |
                    ( a.sign &  b.sign & m_gt));
    return r;
  endfunction

  // Predicate reduction over the three relations.
  function automatic logic f_pred(input logic [3:0] p, input fpcc_rel_t r);
    return (p[2] & r.lt) | (p[1] & r.eq) | (p[0] & r.un);
  endfunction

endpackage

// File: rtl/fpcc_unpack.sv
module fpcc_unpack
  import fpcc_pkg::*;
(
  input  logic [OPW-1:0] bits,
  input  logic           dbl,
  input  logic           absv,
  output fpcc_opnd_t     opnd
);
  always_comb opnd = f_unpack(bits, dbl, absv);
endmodule

// File: rtl/fpcc_order.sv
module fpcc_order
  import fpcc_pkg::*;
(
  input  fpcc_opnd_t a,
  input  fpcc_opnd_t b,
  output fpcc_rel_t  rel,
  output logic       any_snan
);
  fpcc_rel_t ord;
  logic      unord;

  always_comb begin
    ord   = f_order(a, b);
    unord = a.nan | b.nan;
    if (unord) begin
      rel.lt = 1'b0;
      rel.eq = 1'b0;
      rel.un = 1'b1;
    end else begin
      rel = ord;
    end
    any_snan = a.snan | b.snan;
  end
endmodule

// File: rtl/fpcc_eval.sv
module fpcc_eval
  import fpcc_pkg::*;
(
  input  logic [3:0] pred,
  input  fpcc_rel_t  rel,
  input  logic       any_snan,
  output logic       result,
  output logic       invalid
);
  always_comb begin
    result  = f_pred(pred, rel);
    invalid = rel.un & (pred[3] | any_snan);
  end
endmodule

// File: rtl/fp_cond_cmp.sv
module fp_cond_cmp
  import fpcc_pkg::*;
#(
  parameter  int NCC = 8,
  localparam int CCW = (NCC > 1) ? $clog2(NCC) : 1
)(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [OPW-1:0] op_a,
  input  logic [OPW-1:0] op_b,
  input  logic           fmt_dbl,
  input  logic [3:0]     pred,
  input  logic           abs_en,
  input  logic [CCW-1:0] cc_idx,
  output logic           out_done,
  output logic           out_result,
  output logic [NCC-1:0] out_cc_wmask,
  output logic           out_invalid
);

  localparam int NOPS = 2;

  logic [OPW-1:0] op_bus [NOPS];
  fpcc_opnd_t     opnd   [NOPS];

  assign op_bus[0] = op_a;
  assign op_bus[1] = op_b;

  for (genvar g = 0; g < NOPS; g++) begin : g_unp
    fpcc_unpack u_unp (
      .bits (op_bus[g]),
      .dbl  (fmt_dbl),
      .absv (abs_en),
      .opnd (opnd[g])
    );
  end

  fpcc_rel_t rel;
  logic      any_snan;
  logic      cmb_result;
  logic      cmb_invalid;

  fpcc_order u_ord (
    .a        (opnd[0]),
    .b        (opnd[1]),
    .rel      (rel),
    .any_snan (any_snan)
  );

  fpcc_eval u_eval (
    .pred     (pred),
    .rel      (rel),
    .any_snan (any_snan),
    .result   (cmb_result),
    .invalid  (cmb_invalid)
  );

  // Named relation wires for the checker.
  logic rel_lt, rel_eq, rel_un;
  assign rel_lt = rel.lt;
  assign rel_eq = rel.eq;
  assign rel_un = rel.un;

  logic [NCC-1:0] idx_onehot;
  assign idx_onehot = {{(NCC-1){1'b0}}, 1'b1} << cc_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_done     <= 1'b0;
      out_result   <= 1'b0;
      out_invalid  <= 1'b0;
      out_cc_wmask <= '0;
    end else begin
      out_done <= in_valid;
      if (in_valid) begin
        out_result   <= cmb_result;
        out_invalid  <= cmb_invalid;
        out_cc_wmask <= idx_onehot;
      end else begin
        out_result   <= 1'b0;
        out_invalid  <= 1'b0;
        out_cc_wmask <= '0;
      end
    end
  end

endmodule

// File: rtl/fpcc_chk.sv
module fpcc_chk #(
  parameter  int NCC = 8,
  localparam int CCW = (NCC > 1) ? $clog2(NCC) : 1
)(
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic [3:0]     pred,
  input logic [CCW-1:0] cc_idx,
  input logic           rel_lt,
  input logic           rel_eq,
  input logic           rel_un,
  input logic           out_done,
  input logic           out_result,
  input logic [NCC-1:0] out_cc_wmask,
  input logic           out_invalid
);

  // R2: relations are mutually exclusive
  p_rel_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rel_lt, rel_eq, rel_un}));

  // R8: completion pulse follows the strobe by one cycle
  p_done_timing_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_done);
  p_no_spurious_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_done);

  // R7: one-hot mask at the requested index, empty when idle
  p_mask_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_done |-> ($countones(out_cc_wmask) == 1));
  p_mask_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_cc_wmask[$past(cc_idx)]);
  p_mask_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_done |-> (out_cc_wmask == '0));

  // R3: ordered operands never raise invalid
  p_invalid_needs_nan_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rel_un) |=> !out_invalid);

  // R1: empty predicate gives a false result
  p_empty_pred_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pred[2:0] == 3'b000) |=> !out_result);

endmodule

bind fp_cond_cmp fpcc_chk #(.NCC(NCC)) u_chk (.*);

// File: tb/sim_fp_cond_cmp.sv
module sim_fp_cond_cmp;

  localparam int NCC = 8;
  localparam int CCW = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic [63:0]    op_a = '0;
  logic [63:0]    op_b = '0;
  logic           fmt_dbl = 1'b0;
  logic [3:0]     pred = '0;
  logic           abs_en = 1'b0;
  logic [CCW-1:0] cc_idx = '0;
  logic           out_done;
  logic           out_result;
  logic [NCC-1:0] out_cc_wmask;
  logic           out_invalid;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;  // 125 MHz

  fp_cond_cmp #(.NCC(NCC)) u0 (.*);

  // Single-precision encodings
  localparam logic [31:0] S_P1   = 32'h3F80_0000;
  localparam logic [31:0] S_P2   = 32'h4000_0000;
  localparam logic [31:0] S_M1   = 32'hBF80_0000;
  localparam logic [31:0] S_M2   = 32'hC000_0000;
  localparam logic [31:0] S_PZ   = 32'h0000_0000;
  localparam logic [31:0] S_MZ   = 32'h8000_0000;
  localparam logic [31:0] S_DEN  = 32'h0000_0001;
  localparam logic [31:0] S_PINF = 32'h7F80_0000;
  localparam logic [31:0] S_MINF = 32'hFF80_0000;
  localparam logic [31:0] S_QNAN = 32'h7FC0_0000;
  localparam logic [31:0] S_QNAN2= 32'h7FC0_0001;
  localparam logic [31:0] S_SNAN = 32'h7F80_0001;
  // Double-precision encodings
  localparam logic [63:0] D_P1   = 64'h3FF0_0000_0000_0000;
  localparam logic [63:0] D_M3   = 64'hC008_0000_0000_0000;
  localparam logic [63:0] D_MINF = 64'hFFF0_0000_0000_0000;
  localparam logic [63:0] D_QNAN = 64'h7FF8_0000_0000_0000;
  localparam logic [63:0] D_SNAN = 64'h7FF0_0000_0000_0001;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Expected result from the requirement R1 relation table.
  function automatic logic exp_cond(input logic [3:0] p, input logic lt,
                                    input logic eq, input logic un);
    logic hit = 1'b0;
    if (lt && p[2]) hit = 1'b1;
    if (eq && p[1]) hit = 1'b1;
    if (un && p[0]) hit = 1'b1;
    return hit;
  endfunction

  task automatic run(input string req, input logic [63:0] a, input logic [63:0] b,
                     input logic dbl, input logic [3:0] p, input logic ab,
                     input logic [CCW-1:0] idx, input logic lt, input logic eq,
                     input logic un, input logic inv);
    @(negedge clk);
    op_a = a; op_b = b; fmt_dbl = dbl; pred = p; abs_en = ab; cc_idx = idx;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", "done", 64'(out_done), 64'd1);
    check(req, "result", 64'(out_result), 64'(exp_cond(p, lt, eq, un)));
    check(req == "R1" ? "R3" : req, "invalid", 64'(out_invalid), 64'(inv));
    check("R7", "mask", 64'(out_cc_wmask), 64'(8'd1 << idx));
  endtask

  task automatic t_reset;
    check("R8", "reset done", 64'(out_done), 64'd0);
    check("R8", "reset result", 64'(out_result), 64'd0);
    check("R7", "reset mask", 64'(out_cc_wmask), 64'd0);
  endtask

  task automatic t_predicates;  // R1
    run("R1", {32'h0, S_P1}, {32'h0, S_P2}, 1'b0, 4'b0100, 1'b0, 3'd0, 1, 0, 0, 0);
    run("R1", {32'h0, S_P1}, {32'h0, S_P2}, 1'b0, 4'b0010, 1'b0, 3'd1, 1, 0, 0, 0);
    run("R1", {32'h0, S_P1}, {32'h0, S_P2}, 1'b0, 4'b0110, 1'b0, 3'd2, 1, 0, 0, 0);
    run("R1", {32'h0, S_P2}, {32'h0, S_P2}, 1'b0, 4'b0011, 1'b0, 3'd3, 0, 1, 0, 0);
    run("R1", {32'h0, S_P2}, {32'h0, S_P1}, 1'b0, 4'b0111, 1'b0, 3'd4, 0, 0, 0, 0);
  endtask

  task automatic t_ordering;  // R4
    run("R4", {32'h0, S_M1}, {32'h0, S_M2}, 1'b0, 4'b0100, 1'b0, 3'd5, 0, 0, 0, 0);
    run("R4", {32'h0, S_M2}, {32'h0, S_M1}, 1'b0, 4'b0100, 1'b0, 3'd6, 1, 0, 0, 0);
    run("R4", {32'h0, S_PZ}, {32'h0, S_MZ}, 1'b0, 4'b0010, 1'b0, 3'd7, 0, 1, 0, 0);
    run("R4", {32'h0, S_MZ}, {32'h0, S_PZ}, 1'b0, 4'b0100, 1'b0, 3'd0, 0, 1, 0, 0);
    run("R4", {32'h0, S_PZ}, {32'h0, S_DEN}, 1'b0, 4'b0100, 1'b0, 3'd1, 1, 0, 0, 0);
    run("R4", {32'h0, S_MINF}, {32'h0, S_PINF}, 1'b0, 4'b0100, 1'b0, 3'd2, 1, 0, 0, 0);
    run("R4", {32'h0, S_PINF}, {32'h0, S_PINF}, 1'b0, 4'b0010, 1'b0, 3'd3, 0, 1, 0, 0);
    run("R4", D_M3, D_P1, 1'b1, 4'b0100, 1'b0, 3'd4, 1, 0, 0, 0);
    run("R4", D_MINF, D_M3, 1'b1, 4'b0100, 1'b0, 3'd5, 1, 0, 0, 0);
  endtask

  task automatic t_nans;  // R2, R3, R9
    run("R2", {32'h0, S_QNAN}, {32'h0, S_P1}, 1'b0, 4'b0001, 1'b0, 3'd0, 0, 0, 1, 0);
    run("R2", {32'h0, S_P1}, {32'h0, S_QNAN}, 1'b0, 4'b0110, 1'b0, 3'd1, 0, 0, 1, 0);
    run("R3", {32'h0, S_QNAN}, {32'h0, S_QNAN}, 1'b0, 4'b1000, 1'b0, 3'd2, 0, 0, 1, 1);
    run("R3", {32'h0, S_QNAN}, {32'h0, S_P1}, 1'b0, 4'b1001, 1'b0, 3'd3, 0, 0, 1, 1);
    run("R3", {32'h0, S_P1}, {32'h0, S_P2}, 1'b0, 4'b1100, 1'b0, 3'd4, 1, 0, 0, 0);
    run("R9", {32'h0, S_SNAN}, {32'h0, S_P1}, 1'b0, 4'b0001, 1'b0, 3'd5, 0, 0, 1, 1);
    run("R9", {32'h0, S_QNAN2}, {32'h0, S_P1}, 1'b0, 4'b0001, 1'b0, 3'd6, 0, 0, 1, 0);
    run("R9", D_SNAN, D_P1, 1'b1, 4'b0010, 1'b0, 3'd7, 0, 0, 1, 1);
    run("R2", D_P1, D_QNAN, 1'b1, 4'b0101, 1'b0, 3'd0, 0, 0, 1, 0);
    run("R5", {32'h0, S_SNAN}, {32'h0, S_P1}, 1'b0, 4'b0001, 1'b1, 3'd1, 0, 0, 1, 1);
  endtask

  task automatic t_abs;  // R5
    run("R5", {32'h0, S_M2}, {32'h0, S_P1}, 1'b0, 4'b0100, 1'b0, 3'd2, 1, 0, 0, 0);
    run("R5", {32'h0, S_M2}, {32'h0, S_P1}, 1'b0, 4'b0100, 1'b1, 3'd3, 0, 0, 0, 0);
    run("R5", {32'h0, S_M1}, {32'h0, S_P1}, 1'b0, 4'b0010, 1'b1, 3'd4, 0, 1, 0, 0);
    run("R5", D_M3, D_P1, 1'b1, 4'b0100, 1'b1, 3'd5, 0, 0, 0, 0);
  endtask

  task automatic t_format;  // R6
    run("R6", {32'h7000_0000, S_P1}, {32'h0000_0000, S_P2}, 1'b0, 4'b0100, 1'b0, 3'd6, 1, 0, 0, 0);
    run("R6", {32'h7000_0000, S_P1}, {32'h0000_0000, S_P2}, 1'b1, 4'b0100, 1'b0, 3'd7, 0, 0, 0, 0);
    run("R6", {32'hFFFF_FFFF, S_P1}, {32'h0000_0000, S_P1}, 1'b0, 4'b0010, 1'b0, 3'd0, 0, 1, 0, 0);
  endtask

  task automatic t_idle;  // R7, R8
    @(negedge clk);
    check("R8", "idle done", 64'(out_done), 64'd0);
    check("R7", "idle mask", 64'(out_cc_wmask), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_predicates();
    t_ordering();
    t_nans();
    t_abs();
    t_format();
    t_idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule